// File: doc/BRIEF.md
# Power-Stage Protection Guard with Parallel Port Expander

This block sits between a motor-control processor and the power stage it drives. Six PWM gate commands from the processor pass straight through to six gate outputs while no fault is held. Overvoltage and overcurrent inputs from the power stage are synchronized and then held in sticky flags. While any flag is set, every gate output is held low. The flags also drive two interrupt lines and three fault-protection pins back to the processor. Software clears the flags through the bus, and a clear takes effect only after the raw fault inputs have gone away.

The same narrow processor bus reaches four 8-bit port groups. Groups A and B are inputs only. Groups C and D are output registers that are written on the rising edge of the write strobe. The bus also carries a fault status byte. The read path is combinational and comes with a driver-enable output for the data pad, so the bus is released whenever nothing is addressed. An active-low reset pin, driven by the processor, clears the output registers and fault flags and holds every output low.

Top module: `pwr_guard_expander`

## Requirements
- R1: While rst_n is low, out_c and out_d are 0, pwm_out is 0, and irq_ov, irq_oc and pwm_flt are all 0. This holds whatever the pwm_in value is.
- R2: With no fault flag set and rst_n high, pwm_out equals pwm_in bit for bit, combinationally.
- R3: With bus_sel_n and bus_rd_n both low, bus_rd_oe is high. bus_rdata then carries in_a when bus_addr=00, in_b when 01, and the status byte when 10. With bus_addr=11, or with either strobe high, bus_rd_oe is low.
- R4: A write occurs at the first clock edge where bus_wr_n is seen high after it was seen low, provided bus_sel_n was low in the previous cycle. The write uses the address and data of that previous cycle: 00 loads out_c and 01 loads out_d.
- R5: A write at address 11, or a write with bus_sel_n high, leaves out_c and out_d unchanged.
- R6: A fault input that is high across a single clock edge sets its sticky flag, and the flag stays set until it is cleared. The flag is visible after the third rising edge counted from the first edge that sampled the input high.
- R7: While any fault flag is set, pwm_out is 0 whatever pwm_in is.
- R8: irq_ov follows the overvoltage flag and irq_oc follows the overcurrent flag. pwm_flt[0] follows the overvoltage flag, pwm_flt[1] the overcurrent flag, and pwm_flt[2] their OR.
- R9: The status byte has the overvoltage flag in bit 0 and the overcurrent flag in bit 1. Bit 2 is the synchronized overvoltage level and bit 3 the synchronized overcurrent level. Bits 7:4 are 0.
- R10: A write to address 10 with data bit 0 set clears both flags, but only if both synchronized fault levels are low at that edge. Otherwise it has no effect. A write with bit 0 clear has no effect, and a write to address 10 never changes out_c or out_d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Processor-driven reset, active low |
| pwm_in | input | 6 | Gate commands from the processor |
| fault_ov | input | 1 | Overvoltage detect, active high, asynchronous |
| fault_oc | input | 1 | Overcurrent detect, active high, asynchronous |
| bus_sel_n | input | 1 | Data select strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 2 | Port group address |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data toward the processor |
| bus_rd_oe | output | 1 | Driver enable for the data pad |
| in_a | input | 8 | Input port group A |
| in_b | input | 8 | Input port group B |
| out_c | output | 8 | Output port group C |
| out_d | output | 8 | Output port group D |
| pwm_out | output | 6 | Gated gate outputs to the power stage |
| irq_ov | output | 1 | Overvoltage interrupt request |
| irq_oc | output | 1 | Overcurrent interrupt request |
| pwm_flt | output | 3 | Fault-protection pin requests |

## Verification
The bench builds the block with its default parameters: six PWM channels, 8-bit ports and two synchronizer stages. With these values the fault latency is a fixed three edges, so a one-edge pulse and the blocked-clear window can be timed exactly. The 8-bit groups let distinct byte patterns show any crossing between groups A and B, or between C and D. Writes at the status address and at the unused address show that neither output register changes.

// File: rtl/pge_pkg.sv
package pge_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    GRP_IN_A  = 2'b00,
    GRP_IN_B  = 2'b01,
    GRP_STAT  = 2'b10,
    GRP_SPARE = 2'b11
  } grp_sel_e;

  localparam int ST_OV_FLAG = 0;
  localparam int ST_OC_FLAG = 1;
  localparam int ST_OV_LVL  = 2;
  localparam int ST_OC_LVL  = 3;

  function automatic logic [7:0] pack_status(input logic ov_f, input logic oc_f,
                                             input logic ov_l, input logic oc_l);
    logic [7:0] s;
    s = '0;
    s[ST_OV_FLAG] = ov_f;
    s[ST_OC_FLAG] = oc_f;
    s[ST_OV_LVL]  = ov_l;
    s[ST_OC_LVL]  = oc_l;
    return s;
  endfunction
endpackage

// File: rtl/pge_sync.sv
module pge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= '0;
          else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pge_bus_if.sv
module pge_bus_if
  import pge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  input  logic [DW-1:0]     status,
  output logic [DW-1:0]     rdata,
  output logic              rd_oe,
  output logic [DW-1:0]     port_c,
  output logic [DW-1:0]     port_d,
  output logic              clr_req
);
  logic              sel_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              wr_rise, wr_c_evt, wr_d_evt;

  // previous-cycle copy of the bus, used by the write edge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= 1'b1;
      wr_q   <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sel_q  <= sel_n;
      wr_q   <= wr_n;
      addr_q <= addr;
      data_q <= wdata;
    end

  assign wr_rise  = wr_n && !wr_q && !sel_q;
  assign wr_c_evt = wr_rise && (addr_q == GRP_IN_A);
  assign wr_d_evt = wr_rise && (addr_q == GRP_IN_B);
  assign clr_req  = wr_rise && (addr_q == GRP_STAT) && data_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      port_c <= '0;
      port_d <= '0;
    end else begin
      if (wr_c_evt) port_c <= data_q;
      if (wr_d_evt) port_d <= data_q;
    end

  always_comb begin
    rdata = '0;
    rd_oe = 1'b0;
    if (!sel_n && !rd_n) begin
      unique case (grp_sel_e'(addr))
        GRP_IN_A:  begin rdata = in_a;   rd_oe = 1'b1; end
        GRP_IN_B:  begin rdata = in_b;   rd_oe = 1'b1; end
        GRP_STAT:  begin rdata = status; rd_oe = 1'b1; end
        GRP_SPARE: begin rdata = '0;     rd_oe = 1'b0; end
      endcase
    end
  end

  // R4
  port_c_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c_evt |=> port_c == $past(data_q));
  // R4
  port_d_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_d_evt |=> port_d == $past(data_q));
  // R5
  port_c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_c_evt |=> $stable(port_c));
  // R5
  port_d_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_d_evt |=> $stable(port_d));
endmodule

// File: rtl/pge_fault_ctl.sv
module pge_fault_ctl
  import pge_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_ov,
  input  logic          fault_oc,
  input  logic          clr_req,
  output logic          ov_flag,
  output logic          oc_flag,
  output logic          latched,
  output logic [DW-1:0] status
);
  logic [1:0] lvl;
  logic       ov_lvl, oc_lvl, any_lvl, clr_ok;

  pge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({fault_oc, fault_ov}),
    .q    (lvl)
  );

  assign ov_lvl  = lvl[0];
  assign oc_lvl  = lvl[1];
  assign any_lvl = ov_lvl || oc_lvl;
  assign clr_ok  = clr_req && !any_lvl;

  // set wins over clear; clear only when both levels are quiet
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ov_flag <= 1'b0;
      oc_flag <= 1'b0;
    end else begin
      ov_flag <= ov_lvl || (ov_flag && !clr_ok);
      oc_flag <= oc_lvl || (oc_flag && !clr_ok);
    end

  assign latched = ov_flag || oc_flag;

  always_comb begin
    status = '0;
    status[7:0] = pack_status(ov_flag, oc_flag, ov_lvl, oc_lvl);
  end

  // R6
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_lvl |=> latched);
  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !clr_req |=> latched);
  // R10
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched && clr_req && any_lvl |=> latched);
  // R10
  clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !any_lvl |=> !latched);
endmodule

// File: rtl/pwr_guard_expander.sv
module pwr_guard_expander
  import pge_pkg::*;
#(
  parameter int PWM_CH      = 6,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PWM_CH-1:0] pwm_in,
  input  logic              fault_ov,
  input  logic              fault_oc,
  input  logic              bus_sel_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rd_oe,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  output logic [DW-1:0]     out_c,
  output logic [DW-1:0]     out_d,
  output logic [PWM_CH-1:0] pwm_out,
  output logic              irq_ov,
  output logic              irq_oc,
  output logic [2:0]        pwm_flt
);
  logic          clr_req, ov_flag, oc_flag, fault_latched, gate_en;
  logic [DW-1:0] status;

  pge_bus_if #(.DW(DW)) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (bus_sel_n),
    .rd_n   (bus_rd_n),
    .wr_n   (bus_wr_n),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .in_a   (in_a),
    .in_b   (in_b),
    .status (status),
    .rdata  (bus_rdata),
    .rd_oe  (bus_rd_oe),
    .port_c (out_c),
    .port_d (out_d),
    .clr_req(clr_req)
  );

  pge_fault_ctl #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault_ov(fault_ov),
    .fault_oc(fault_oc),
    .clr_req (clr_req),
    .ov_flag (ov_flag),
    .oc_flag (oc_flag),
    .latched (fault_latched),
    .status  (status)
  );

  assign gate_en = rst_n && !fault_latched;

  generate
    for (genvar ch = 0; ch < PWM_CH; ch++) begin : g_gate
      assign pwm_out[ch] = gate_en && pwm_in[ch];
    end
  endgenerate

  assign irq_ov     = ov_flag;
  assign irq_oc     = oc_flag;
  assign pwm_flt[0] = ov_flag;
  assign pwm_flt[1] = oc_flag;
  assign pwm_flt[2] = fault_latched;

  // R7
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_latched) && fault_latched |-> pwm_out == '0);
  // R8
  flt_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> pwm_flt[2] && (irq_ov || irq_oc));
endmodule

// File: tb/pwr_guard_expander_bench.sv
module pwr_guard_expander_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [5:0] pwm_in = '0;
  logic       fault_ov = 0, fault_oc = 0;
  logic       sel_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, in_a = '0, in_b = '0;
  logic [7:0] rdata, out_c, out_d;
  logic       rd_oe, irq_ov, irq_oc;
  logic [5:0] pwm_out;
  logic [2:0] pwm_flt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_guard_expander u_pwr_guard_expander (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .fault_ov(fault_ov), .fault_oc(fault_oc),
    .bus_sel_n(sel_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rd_oe(rd_oe), .in_a(in_a), .in_b(in_b),
    .out_c(out_c), .out_d(out_d), .pwm_out(pwm_out), .irq_ov(irq_ov), .irq_oc(irq_oc),
    .pwm_flt(pwm_flt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    sel_n = sel; addr = a; wdata = d; wr_n = 0;
    @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    sel_n = 1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    sel_n = 0; rd_n = 0; addr = a;
    #1;
    d = rdata; oe = rd_oe;
    @(negedge clk);
    sel_n = 1; rd_n = 1;
  endtask

  task automatic t_reset();
    pwm_in = 6'h3F;
    #1;
    chk("R1 pwm_out in reset", pwm_out, 0);
    chk("R1 ports in reset", {out_c, out_d}, 0);
    chk("R1 irq/flt in reset", {irq_ov, irq_oc, pwm_flt}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_pass();
    foreach (pat_list[i]) begin
      pwm_in = pat_list[i];
      #1;
      chk("R2 pwm pass-through", pwm_out, pat_list[i]);
    end
  endtask
  logic [5:0] pat_list [4] = '{6'h15, 6'h2A, 6'h3F, 6'h01};

  task automatic t_read();
    logic [7:0] d; logic oe;
    in_a = 8'hA5; in_b = 8'h3C;
    bus_read(2'b00, d, oe); chk("R3 read group A", {oe, d}, {1'b1, 8'hA5});
    bus_read(2'b01, d, oe); chk("R3 read group B", {oe, d}, {1'b1, 8'h3C});
    bus_read(2'b11, d, oe); chk("R3 spare address releases bus", oe, 0);
    @(negedge clk); sel_n = 1; rd_n = 0; addr = 2'b00; #1;
    chk("R3 no select releases bus", rd_oe, 0);
    rd_n = 1;
    bus_read(2'b10, d, oe); chk("R9 idle status byte", {oe, d}, {1'b1, 8'h00});
  endtask

  task automatic t_write();
    bus_write(2'b00, 8'h5A, 0); chk("R4 write group C", out_c, 8'h5A);
    bus_write(2'b01, 8'hC3, 0); chk("R4 write group D", out_d, 8'hC3);
    bus_write(2'b11, 8'hFF, 0); chk("R5 spare write ignored", {out_c, out_d}, 16'h5AC3);
    bus_write(2'b00, 8'h11, 1); chk("R5 unselected write ignored", {out_c, out_d}, 16'h5AC3);
    bus_write(2'b10, 8'h00, 0); chk("R10 status write keeps ports", {out_c, out_d}, 16'h5AC3);
  endtask

  task automatic t_fault_pulse();
    logic [7:0] d; logic oe;
    pwm_in = 6'h3F;
    @(negedge clk); fault_ov = 1;
    @(negedge clk); fault_ov = 0;
    @(negedge clk);
    chk("R6 not yet latched after 2 edges", pwm_flt, 0);
    @(negedge clk);
    chk("R6/R7 short pulse blocks pwm", pwm_out, 0);
    chk("R8 ov reporting", {irq_ov, irq_oc, pwm_flt}, {1'b1, 1'b0, 3'b101});
    repeat (3) @(negedge clk);
    chk("R6 flag sticky", irq_ov, 1);
    bus_read(2'b10, d, oe); chk("R9 status ov flag", d, 8'h01);
    bus_write(2'b10, 8'h00, 0); chk("R10 bit0 clear ignored", irq_ov, 1);
    bus_write(2'b10, 8'h01, 0); chk("R10 clear with quiet inputs", {irq_ov, pwm_flt}, 0);
    #1; chk("R2 pwm restored", pwm_out, 6'h3F);
  endtask

  task automatic t_fault_hold();
    logic [7:0] d; logic oe;
    @(negedge clk); fault_oc = 1;
    repeat (4) @(negedge clk);
    chk("R8 oc reporting", {irq_ov, irq_oc, pwm_flt}, {1'b0, 1'b1, 3'b110});
    bus_read(2'b10, d, oe); chk("R9 status oc flag and level", d, 8'h0A);
    bus_write(2'b10, 8'h01, 0); chk("R10 clear blocked while active", irq_oc, 1);
    pwm_in = 6'h2D; #1;
    chk("R7 pwm blocked with new pattern", pwm_out, 0);
    fault_oc = 0;
    repeat (3) @(negedge clk);
    bus_read(2'b10, d, oe); chk("R9 status flag without level", d, 8'h02);
    bus_write(2'b10, 8'h01, 0); chk("R10 clear after release", irq_oc, 0);
  endtask

  task automatic t_reset_mid();
    pwm_in = 6'h3F;
    bus_write(2'b00, 8'hAA, 0);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 reset clears ports", {out_c, out_d}, 0);
    chk("R1 reset forces pwm low", pwm_out, 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    t_reset();
    t_pass();
    t_read();
    t_write();
    t_fault_pulse();
    t_fault_hold();
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule